// File: doc/BRIEF.md
# Host-to-Microcontroller Byte Mailbox

This block connects a memory-mapped host register port to a small system microcontroller. The host writes command and parameter bytes into a data register. Each byte goes into an eight-entry outbound queue, and the microcontroller drains that queue through a byte-wide valid/ready stream. In the other direction, bytes that the microcontroller presents land in an eight-entry inbound queue. The host takes them one at a time by reading the same data register.

A conversation runs as follows. The host sends an opcode byte and any parameter bytes. It then collects one acknowledge byte and a fixed number of response bytes, most significant first. The host may poll the status register or rely on the single interrupt line. That line is raised by sticky, edge-set request flags, each with its own enable. If a byte arrives while the inbound queue is full, the byte is dropped and an overflow flag is latched. The flag stays set until the host clears it.

Top module: `uc_mailbox_bridge`

## Requirements
- R1: Word offset 0 selects the interrupt register, offset 1 the data register and offset 2 the status register. Offsets 3 to 7 read as zero and ignore writes.
- R2: A host write to the data register takes bits 15:8 of the written word as the byte and ignores all other bits. That byte is queued and leaves on `tx_data` with `tx_valid` high, in write order, one byte per cycle in which `tx_valid` and `tx_ready` are both high.
- R3: A host read of the data register returns the oldest inbound byte in bits 15:8, with all other bits zero, and removes that byte. A read while the inbound queue is empty returns zero and removes nothing.
- R4: The outbound queue holds 8 bytes. A data write while it is full is discarded.
- R5: Status bit 0 is outbound queue empty, bit 1 is outbound queue not full, bit 2 is inbound queue not empty and bit 3 is inbound overflow. Bits 0 to 2 follow the queue state live, and bits 31:4 read as zero.
- R6: `rx_valid` high while the inbound queue holds 8 bytes drops that byte and sets status bit 3. The bit stays set until the host writes 1 to status bit 3. Writing ones to status bits 0 to 2 changes nothing.
- R7: Interrupt register bits 3:0 are request flags for, in order, outbound empty, outbound not full, inbound not empty and overflow. Each flag is set on a rising edge of its condition and stays set until the host writes 1 to that bit of the interrupt register. A condition that is still high after the clear does not set the flag again.
- R8: Interrupt register bits 7:4 are enable masks in the same order. They are loaded directly by every write to the interrupt register and read back. `irq` is high exactly when some request flag and its mask bit are both set.
- R9: After reset both queues are empty, the interrupt register reads 0x00, the status register reads 0x3 and `irq` is low.
- R10: `rx_ready` is low exactly while the inbound queue is full, and `tx_valid` is high exactly while the outbound queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Host word offset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (pops on data offset) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from `reg_sel` |
| irq | output | 1 | Interrupt to the host |
| tx_valid | output | 1 | Outbound byte available |
| tx_ready | input | 1 | Microcontroller accepts outbound byte |
| tx_data | output | 8 | Outbound byte |
| rx_valid | input | 1 | Microcontroller presents an inbound byte |
| rx_ready | output | 1 | Inbound queue has room |
| rx_data | input | 8 | Inbound byte |

## Verification
On every cycle, the embedded properties check the following. A write to a full outbound queue leaves its fill level unchanged, and a read of an empty inbound queue leaves it empty. The fill level never exceeds the depth. Request flags and masks hold when no interrupt-register write occurs. A dropped inbound byte always leaves the overflow flag set. Byte ordering, the placement of data in bits 15:8, the live status values, edge-only setting of requests after a clear, and the interrupt mask gating are shown by the directed scenarios.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int SEL_W    = 3;
    localparam int NUM_COND = 4;

    localparam logic [SEL_W-1:0] SEL_INTR = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DATA = 3'd1;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd2;

    // Condition vector: bit 0 out-empty, 1 out-not-full, 2 in-not-empty, 3 overflow
    typedef struct packed {
        logic ovf;
        logic rx_ne;
        logic tx_nf;
        logic tx_e;
    } cond_t;

    localparam cond_t COND_AT_RESET = '{ovf: 1'b0, rx_ne: 1'b0, tx_nf: 1'b1, tx_e: 1'b1};

    function automatic logic [WORD_W-1:0] place_byte(input logic [BYTE_W-1:0] b);
        return {{(WORD_W-16){1'b0}}, b, 8'h00};
    endfunction

    function automatic logic [BYTE_W-1:0] take_byte(input logic [WORD_W-1:0] w);
        return w[15:8];
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] level
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                store[wr_ptr] <= din;
                wr_ptr        <= next_ptr(wr_ptr);
            end
            if (do_pop) rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    assert_full_push_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop |=> level == CNT_W'(DEPTH));
    assert_empty_pop_hold_R3: assert property (@(posedge clk) disable iff (rst)
        empty && pop && !push |=> empty);
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                live_tx_e,
    input  logic                live_tx_nf,
    input  logic                live_rx_ne,
    input  logic                rx_drop,
    input  logic                intr_wr,
    input  logic [7:0]          intr_wdata,
    input  logic                ovf_clr,
    output logic [NUM_COND-1:0] req,
    output logic [NUM_COND-1:0] mask,
    output logic                ovf_flag,
    output logic                irq
);
    cond_t cur, prev;
    logic [NUM_COND-1:0] rise, clr;

    assign cur  = '{ovf: ovf_flag, rx_ne: live_rx_ne, tx_nf: live_tx_nf, tx_e: live_tx_e};
    assign rise = cur & ~prev;
    assign clr  = intr_wr ? intr_wdata[NUM_COND-1:0] : '0;
    assign irq  = |(req & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= COND_AT_RESET;
            req      <= '0;
            mask     <= '0;
            ovf_flag <= 1'b0;
        end else begin
            prev <= cur;
            req  <= (req & ~clr) | rise;
            if (intr_wr) mask <= intr_wdata[2*NUM_COND-1:NUM_COND];
            if (rx_drop)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    assert_drop_sets_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        rx_drop |=> ovf_flag);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !ovf_clr |=> ovf_flag);
    assert_req_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !intr_wr |=> (req & $past(req)) == $past(req));
    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !intr_wr |=> $stable(mask));
    assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> mask != '0);
endmodule

// File: rtl/uc_mailbox_bridge.sv
module uc_mailbox_bridge
    import mbx_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1),
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_data
);
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [TX_CNT_W-1:0] tx_level;
    logic [RX_CNT_W-1:0] rx_level;
    logic [BYTE_W-1:0]   rx_head;
    logic [NUM_COND-1:0] req, mask;
    logic ovf_flag, wr_data, rd_data, wr_intr, wr_stat, rx_drop;
    cond_t status;

    assign wr_data  = reg_wr && (reg_sel == SEL_DATA);
    assign rd_data  = reg_rd && (reg_sel == SEL_DATA);
    assign wr_intr  = reg_wr && (reg_sel == SEL_INTR);
    assign wr_stat  = reg_wr && (reg_sel == SEL_STAT);
    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;
    assign rx_drop  = rx_valid && rx_full;
    assign status   = '{ovf: ovf_flag, rx_ne: !rx_empty, tx_nf: !tx_full, tx_e: tx_empty};

    mbx_fifo #(.DEPTH(TX_DEPTH), .WIDTH(BYTE_W)) tx_q (
        .clk(clk), .rst(rst),
        .push(wr_data), .din(take_byte(reg_wdata)),
        .pop(tx_valid && tx_ready), .dout(tx_data),
        .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    mbx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) rx_q (
        .clk(clk), .rst(rst),
        .push(rx_valid), .din(rx_data),
        .pop(rd_data), .dout(rx_head),
        .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    mbx_irq_ctrl irq_ctl (
        .clk(clk), .rst(rst),
        .live_tx_e(tx_empty), .live_tx_nf(!tx_full), .live_rx_ne(!rx_empty),
        .rx_drop(rx_drop),
        .intr_wr(wr_intr), .intr_wdata(reg_wdata[7:0]),
        .ovf_clr(wr_stat && reg_wdata[3]),
        .req(req), .mask(mask), .ovf_flag(ovf_flag), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_INTR: reg_rdata = {{(WORD_W-2*NUM_COND){1'b0}}, mask, req};
            SEL_DATA: reg_rdata = rx_empty ? '0 : place_byte(rx_head);
            SEL_STAT: reg_rdata = {{(WORD_W-NUM_COND){1'b0}}, status};
            default:  reg_rdata = '0;
        endcase
    end

    assert_rx_level_stable_on_drop_R6: assert property (@(posedge clk) disable iff (rst)
        rx_drop && !rd_data |=> rx_level == RX_CNT_W'(RX_DEPTH));
    assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rd_data && rx_level == '0 |-> reg_rdata == '0);
    assert_tx_full_level_R4: assert property (@(posedge clk) disable iff (rst)
        tx_level == TX_CNT_W'(TX_DEPTH) && !tx_ready |=> tx_level == TX_CNT_W'(TX_DEPTH));
endmodule

// File: tb/uc_mailbox_bridge_tb_top.sv
module uc_mailbox_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, tx_valid, rx_ready;
    logic        tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  tx_data;
    logic [7:0]  rx_data = '0;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    uc_mailbox_bridge dut_i (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic uc_send(input logic [7:0] b);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic uc_take(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, {31'b0, tx_valid}, 32'd1);
        check(req, {24'b0, tx_data}, {24'b0, exp});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        host_read(3'd0, v); check("R9 intr", v, 32'h0);
        host_read(3'd2, v); check("R9 status", v, 32'h3);
        check("R9 irq", {31'b0, irq}, 32'd0);
        check("R10 rx_ready", {31'b0, rx_ready}, 32'd1);
        check("R10 tx_valid", {31'b0, tx_valid}, 32'd0);
        host_write(3'd5, 32'hFFFF_FFFF);
        for (int s = 3; s < 8; s++) begin
            host_read(3'(s), v); check("R1 reserved", v, 32'h0);
        end
        host_read(3'd2, v); check("R1 reserved write ignored", v, 32'h3);
    endtask

    task automatic t_tx_path();
        logic [31:0] v;
        host_write(3'd1, 32'hFFFF_A5FF);
        host_write(3'd1, 32'h1234_3C56);
        host_read(3'd2, v); check("R5 status out busy", v, 32'h2);
        uc_take("R2 first byte", 8'hA5);
        uc_take("R2 second byte", 8'h3C);
        @(negedge clk);
        check("R10 tx_valid idle", {31'b0, tx_valid}, 32'd0);
    endtask

    task automatic t_tx_full();
        logic [31:0] v;
        for (int i = 0; i < 9; i++) host_write(3'd1, {16'h0, 8'(8'h80 + i), 8'h0});
        host_read(3'd2, v); check("R5 out full", v, 32'h0);
        for (int i = 0; i < 8; i++) uc_take("R4 order", 8'(8'h80 + i));
        @(negedge clk);
        check("R4 ninth dropped", {31'b0, tx_valid}, 32'd0);
    endtask

    task automatic t_rx_path();
        logic [31:0] v;
        uc_send(8'hC3); uc_send(8'h7E);
        host_read(3'd2, v); check("R5 in not empty", v, 32'h7);
        host_read(3'd1, v); check("R3 first read", v, 32'h0000_C300);
        host_read(3'd1, v); check("R3 second read", v, 32'h0000_7E00);
        host_read(3'd1, v); check("R3 empty read", v, 32'h0);
        host_read(3'd2, v); check("R5 in empty", v, 32'h3);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) uc_send(8'(8'h10 + i));
        check("R10 rx_ready full", {31'b0, rx_ready}, 32'd0);
        uc_send(8'hEE);
        host_read(3'd2, v); check("R6 overflow set", v, 32'hF);
        host_write(3'd2, 32'h7);
        host_read(3'd2, v); check("R6 low bits no effect", v, 32'hF);
        host_read(3'd0, v); check("R7 overflow request", v & 32'h8, 32'h8);
        host_write(3'd2, 32'h8);
        host_read(3'd2, v); check("R6 overflow cleared", v, 32'h7);
        for (int i = 0; i < 8; i++) begin
            host_read(3'd1, v); check("R6 kept bytes", v, {16'h0, 8'(8'h10 + i), 8'h0});
        end
        host_read(3'd1, v); check("R6 dropped byte absent", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        host_write(3'd0, 32'h0F);
        idle(2);
        host_read(3'd0, v); check("R7 cleared no re-set", v, 32'h0);
        host_write(3'd0, 32'h40);
        check("R8 no request no irq", {31'b0, irq}, 32'd0);
        uc_send(8'h99);
        idle(2);
        check("R8 irq rx", {31'b0, irq}, 32'd1);
        host_read(3'd0, v); check("R7 rx request", v, 32'h44);
        host_write(3'd0, 32'h44);
        host_read(3'd0, v); check("R7 w1c", v, 32'h40);
        check("R8 irq after clear", {31'b0, irq}, 32'd0);
        host_read(3'd1, v); check("R3 irq byte", v, 32'h0000_9900);
        host_write(3'd0, 32'h14);
        host_write(3'd1, 32'h0000_5500);
        uc_take("R2 irq tx byte", 8'h55);
        idle(2);
        host_read(3'd0, v); check("R7 out empty edge", v, 32'h11);
        check("R8 irq tx", {31'b0, irq}, 32'd1);
        host_write(3'd0, 32'h01);
        host_read(3'd0, v); check("R8 mask rewrite", v, 32'h0);
        check("R8 irq off", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_path();
        t_tx_full();
        t_rx_path();
        t_overflow();
        t_irq();
        summary();
        $finish;
    end
endmodule